// File: doc/BRIEF.md
# Triplet-Framed Configuration Write Port

This block is a write-only target on a two-wire serial bus with open-drain data. A controller opens a transfer with START and sends an address byte. The target acknowledges it only when the byte matches its own address. The controller then sends configuration bytes, which are grouped in threes. In the first byte of each triplet, bits [7:6] name the register group that the triplet fills. The second and third bytes are placed by their position in the triplet. Together the four groups hold a 15-bit main divider value, a 9-bit reference divider value, three 4-bit threshold codes, three 8-bit converter codes, five loop-control bits, three switch bits and four mode bits.

Incoming bytes go into a shadow copy. At START from an idle bus, the shadow copy is reloaded from the active copy. At STOP, an error-free transfer copies the shadow into the active outputs and raises `commit_o` for one clock. SCL and SDA are oversampled by the system clock, which must run at least 8 times faster than SCL. START and STOP are recognised as SDA edges while SCL is high. The address-select pin sets bit 2 of the address.

The controller has seven states:
- IDLE: the bus is free. START goes to ADDR.
- ADDR: the address byte is being shifted in. A match goes to ADDR_ACK; a miss goes to IGNORE.
- ADDR_ACK: SDA is held low. The next SCL fall goes to DATA.
- DATA: a data byte is being shifted in. The eighth bit goes to DATA_ACK.
- DATA_ACK: SDA is held low. The next SCL fall goes back to DATA.
- IGNORE: the address missed. START goes to ADDR.
- HALT: a framing error occurred. Only STOP leaves this state.

From any state, STOP goes to IDLE. A repeated START outside IDLE goes to ADDR, or to HALT when a triplet is still open.

Top module: `trip_cfg_slave`

## Requirements
- R1: The address byte 1,1,0,0,0,S,0,0 (MSB first) is acknowledged. S is the level of `adr_sel_i`. The acknowledge is SDA held low for the ninth SCL clock of the byte.
- R2: An address that does not match, including the match with bit 0 set (a read), gets no acknowledge. Later bytes are not acknowledged, and a STOP ends the transfer without a commit.
- R3: Bits [7:6] of the first byte of a triplet select the group: 00 = A, 01 = B, 10 = C, 11 = D. The second and third bytes are placed by their position.
- R4: Group A: byte 1 bits [2:0] → main divider [14:12]; byte 2 bits [5:0] → [11:6]; byte 3 bits [5:0] → [5:0].
- R5: Group B: byte 1 bit 4 → reference divider [8] and bits [3:0] → threshold A. Byte 2 bits [7:4] → reference [7:4] and bits [3:0] → threshold B. Byte 3 bits [7:4] → reference [3:0] and bits [3:0] → threshold C.
- R6: Group C: byte 2 → converter code A; byte 3 → converter code B. The low six bits of byte 1 have no effect.
- R7: Group D: byte 1 bits [4:0] → loop-control bits; byte 2 bits [7:5] → switch bits and bits [3:0] → mode bits; byte 3 → converter code C.
- R8: Outputs change only when an error-free STOP commits, three clocks after the SDA rise. `commit_o` is high for exactly that one clock.
- R9: A STOP in the middle of a triplet commits the bytes already received. Fields of the unsent bytes keep their old values.
- R10: A repeated START while a triplet is open is a framing error. From then on nothing is acknowledged, the STOP commits nothing, and the next transfer starts from the active values.
- R11: A repeated START at a triplet boundary, followed by a matching address, continues the transfer. One STOP then commits all of its bytes.
- R12: During reset, every field is 0, `commit_o` is 0 and SDA is released.
- R13: The SDA drive changes only while SCL is low. It is released after the SCL fall that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8× SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| adr_sel_i | input | 1 | Address select, becomes address bit 2 |
| sda_drive_o | output | 1 | 1 = pull SDA low (acknowledge) |
| main_div_o | output | 15 | Main divider value |
| ref_div_o | output | 9 | Reference divider value |
| thr_a_o | output | 4 | Threshold code A |
| thr_b_o | output | 4 | Threshold code B |
| thr_c_o | output | 4 | Threshold code C |
| dac_a_o | output | 8 | Converter code A |
| dac_b_o | output | 8 | Converter code B |
| dac_c_o | output | 8 | Converter code C |
| loop_ctl_o | output | 5 | Loop-control bits |
| sw_o | output | 3 | Switch bits |
| mode_o | output | 4 | Mode bits |
| commit_o | output | 1 | One-clock pulse when values are committed |

## Verification
The assertions check three things on every cycle. Outputs stay frozen except in the commit clock. The commit pulse never lasts two clocks. The acknowledge drive never moves while SCL is high.

Several behaviours can only be shown by the bench's scenarios, because each depends on a whole byte sequence rather than on one cycle:
- address matching for both select levels, and the refusals;
- the field placement of each group;
- partial triplets at STOP;
- the discard after a mid-triplet restart;
- continuation after a restart at a triplet boundary.

// File: rtl/tw_trip_pkg.sv
package tw_trip_pkg;
    localparam int BYTE_BITS   = 8;
    localparam int TRIPLET_LEN = 3;
    localparam int MAIN_W      = 15;
    localparam int REF_W       = 9;
    localparam int THR_W       = 4;
    localparam int DAC_W       = 8;
    localparam int CTL_W       = 5;
    localparam int SW_W        = 3;
    localparam int MODE_W      = 4;
    localparam logic [4:0] DEV_ID_HI = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE,
        ST_HALT
    } tw_state_e;

    typedef enum logic [1:0] {
        GRP_A = 2'b00,
        GRP_B = 2'b01,
        GRP_C = 2'b10,
        GRP_D = 2'b11
    } grp_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main_div;
        logic [REF_W-1:0]  ref_div;
        logic [THR_W-1:0]  thr_a;
        logic [THR_W-1:0]  thr_b;
        logic [THR_W-1:0]  thr_c;
        logic [DAC_W-1:0]  dac_a;
        logic [DAC_W-1:0]  dac_b;
        logic [DAC_W-1:0]  dac_c;
        logic [CTL_W-1:0]  loop_ctl;
        logic [SW_W-1:0]   sw;
        logic [MODE_W-1:0] mode;
    } cfg_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_s;
    logic                   scl_p;
    logic                   sda_p;

    // Idle bus level is high, so reset to 1 to avoid false events.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_ff[i] <= scl_ff[i-1];
                sda_ff[i] <= sda_ff[i-1];
            end
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s    = scl_ff[SYNC_STAGES-1];
    assign sda_s    = sda_ff[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
    import tw_trip_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_ev,
    input  logic                 stop_ev,
    input  logic                 adr_sel,
    output logic                 sda_drive,
    output logic                 load_sh,
    output logic                 wr_en,
    output logic [1:0]           wr_grp,
    output logic [1:0]           wr_slot,
    output logic [BYTE_BITS-1:0] wr_byte,
    output logic                 commit_stb,
    output logic                 commit_q
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(BYTE_BITS);
    localparam logic [1:0]       SLOT_LAST = 2'(TRIPLET_LEN - 1);

    tw_state_e            st, nxt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic [1:0]           slot;
    logic [1:0]           grp;
    logic                 sess_live;
    logic                 err;
    logic                 byte_end;
    logic                 addr_hit;
    logic                 mid_trip;

    assign byte_end = scl_fall && (bit_cnt == CNT_FULL);
    assign addr_hit = (shreg == {DEV_ID_HI, adr_sel, 2'b00});
    assign mid_trip = sess_live && (slot != 2'd0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (start_ev) nxt = ST_ADDR;
            ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK: if (scl_fall) nxt = ST_DATA;
            ST_DATA:     if (byte_end) nxt = ST_DATA_ACK;
            ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
            ST_IGNORE:   nxt = st;
            ST_HALT:     nxt = st;
            default:     nxt = ST_IDLE;
        endcase
        if (start_ev && (st != ST_IDLE))
            nxt = ((st == ST_HALT) || mid_trip) ? ST_HALT : ST_ADDR;
        if (stop_ev)
            nxt = ST_IDLE;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            slot      <= '0;
            grp       <= '0;
            sess_live <= 1'b0;
            err       <= 1'b0;
            sda_drive <= 1'b0;
            commit_q  <= 1'b0;
        end else begin
            sda_drive <= (nxt == ST_ADDR_ACK) || (nxt == ST_DATA_ACK);
            commit_q  <= commit_stb;
            if (start_ev) begin
                bit_cnt <= '0;
                if (st == ST_IDLE) begin
                    sess_live <= 1'b0;
                    err       <= 1'b0;
                    slot      <= '0;
                end else if ((st != ST_HALT) && mid_trip) begin
                    err <= 1'b1;
                end
            end else if (stop_ev) begin
                sess_live <= 1'b0;
                err       <= 1'b0;
                bit_cnt   <= '0;
            end else begin
                if (scl_rise && ((st == ST_ADDR) || (st == ST_DATA)) && (bit_cnt < CNT_FULL)) begin
                    shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_end && (st == ST_ADDR) && addr_hit)
                    sess_live <= 1'b1;
                if (byte_end && (st == ST_DATA)) begin
                    if (slot == 2'd0) grp <= shreg[BYTE_BITS-1 -: 2];
                    slot <= (slot == SLOT_LAST) ? 2'd0 : slot + 2'd1;
                end
                if (scl_fall && ((st == ST_ADDR_ACK) || (st == ST_DATA_ACK)))
                    bit_cnt <= '0;
            end
        end
    end

    assign wr_en      = byte_end && (st == ST_DATA);
    assign wr_grp     = (slot == 2'd0) ? shreg[BYTE_BITS-1 -: 2] : grp;
    assign wr_slot    = slot;
    assign wr_byte    = shreg;
    assign load_sh    = start_ev && (st == ST_IDLE);
    assign commit_stb = stop_ev && sess_live && !err;
endmodule

// File: rtl/tw_cfg_bank.sv
module tw_cfg_bank
    import tw_trip_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_sh,
    input  logic                 wr_en,
    input  logic [1:0]           wr_grp,
    input  logic [1:0]           wr_slot,
    input  logic [BYTE_BITS-1:0] wr_byte,
    input  logic                 commit_stb,
    output cfg_t                 act
);
    cfg_t sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            act <= '0;
        end else begin
            if (load_sh) begin
                sh <= act;
            end else if (wr_en) begin
                unique case (grp_e'(wr_grp))
                    GRP_A: begin
                        if (wr_slot == 2'd0) sh.main_div[14:12] <= wr_byte[2:0];
                        if (wr_slot == 2'd1) sh.main_div[11:6]  <= wr_byte[5:0];
                        if (wr_slot == 2'd2) sh.main_div[5:0]   <= wr_byte[5:0];
                    end
                    GRP_B: begin
                        if (wr_slot == 2'd0) begin
                            sh.ref_div[8] <= wr_byte[4];
                            sh.thr_a      <= wr_byte[3:0];
                        end
                        if (wr_slot == 2'd1) begin
                            sh.ref_div[7:4] <= wr_byte[7:4];
                            sh.thr_b        <= wr_byte[3:0];
                        end
                        if (wr_slot == 2'd2) begin
                            sh.ref_div[3:0] <= wr_byte[7:4];
                            sh.thr_c        <= wr_byte[3:0];
                        end
                    end
                    GRP_C: begin
                        if (wr_slot == 2'd1) sh.dac_a <= wr_byte;
                        if (wr_slot == 2'd2) sh.dac_b <= wr_byte;
                    end
                    GRP_D: begin
                        if (wr_slot == 2'd0) sh.loop_ctl <= wr_byte[4:0];
                        if (wr_slot == 2'd1) begin
                            sh.sw   <= wr_byte[7:5];
                            sh.mode <= wr_byte[3:0];
                        end
                        if (wr_slot == 2'd2) sh.dac_c <= wr_byte;
                    end
                    default: sh <= sh;
                endcase
            end
            if (commit_stb)
                act <= sh;
        end
    end
endmodule

// File: rtl/trip_cfg_slave.sv
module trip_cfg_slave
    import tw_trip_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              adr_sel_i,
    output logic              sda_drive_o,
    output logic [MAIN_W-1:0] main_div_o,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [THR_W-1:0]  thr_a_o,
    output logic [THR_W-1:0]  thr_b_o,
    output logic [THR_W-1:0]  thr_c_o,
    output logic [DAC_W-1:0]  dac_a_o,
    output logic [DAC_W-1:0]  dac_b_o,
    output logic [DAC_W-1:0]  dac_c_o,
    output logic [CTL_W-1:0]  loop_ctl_o,
    output logic [SW_W-1:0]   sw_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              commit_o
);
    logic                 sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic                 load_sh, wr_en, commit_stb;
    logic [1:0]           wr_grp, wr_slot;
    logic [BYTE_BITS-1:0] wr_byte;
    cfg_t                 act;

    tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tw_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .adr_sel    (adr_sel_i),
        .sda_drive  (sda_drive_o),
        .load_sh    (load_sh),
        .wr_en      (wr_en),
        .wr_grp     (wr_grp),
        .wr_slot    (wr_slot),
        .wr_byte    (wr_byte),
        .commit_stb (commit_stb),
        .commit_q   (commit_o)
    );

    tw_cfg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_sh    (load_sh),
        .wr_en      (wr_en),
        .wr_grp     (wr_grp),
        .wr_slot    (wr_slot),
        .wr_byte    (wr_byte),
        .commit_stb (commit_stb),
        .act        (act)
    );

    assign main_div_o = act.main_div;
    assign ref_div_o  = act.ref_div;
    assign thr_a_o    = act.thr_a;
    assign thr_b_o    = act.thr_b;
    assign thr_c_o    = act.thr_c;
    assign dac_a_o    = act.dac_a;
    assign dac_b_o    = act.dac_b;
    assign dac_c_o    = act.dac_c;
    assign loop_ctl_o = act.loop_ctl;
    assign sw_o       = act.sw;
    assign mode_o     = act.mode;
endmodule

// File: rtl/trip_cfg_slave_chk.sv
module trip_cfg_slave_chk
    import tw_trip_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_drive_o,
    input logic [MAIN_W-1:0] main_div_o,
    input logic [REF_W-1:0]  ref_div_o,
    input logic [THR_W-1:0]  thr_a_o,
    input logic [THR_W-1:0]  thr_b_o,
    input logic [THR_W-1:0]  thr_c_o,
    input logic [DAC_W-1:0]  dac_a_o,
    input logic [DAC_W-1:0]  dac_b_o,
    input logic [DAC_W-1:0]  dac_c_o,
    input logic [CTL_W-1:0]  loop_ctl_o,
    input logic [SW_W-1:0]   sw_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              commit_o
);
    logic [71:0] cfg_vec;
    assign cfg_vec = {main_div_o, ref_div_o, thr_a_o, thr_b_o, thr_c_o,
                      dac_a_o, dac_b_o, dac_c_o, loop_ctl_o, sw_o, mode_o};

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> (!commit_o && !sda_drive_o));

    assert_commit_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> $stable(cfg_vec));

    assert_drive_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_o) |-> !scl_i);
endmodule

bind trip_cfg_slave trip_cfg_slave_chk u_chk (.*);

// File: tb/tb_trip_cfg_slave.sv
module tb_trip_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst_n;
    logic scl_m, sda_m, adr_sel;
    logic sda_drive;
    logic [14:0] main_div;
    logic [8:0]  ref_div;
    logic [3:0]  thr_a, thr_b, thr_c;
    logic [7:0]  dac_a, dac_b, dac_c;
    logic [4:0]  loop_ctl;
    logic [2:0]  sw;
    logic [3:0]  mode;
    logic        commit;
    wire         sda_bus = sda_m & ~sda_drive;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Reference model state
    logic [71:0] e_act = '0;
    logic [71:0] e_sh  = '0;
    logic        e_commit = 1'b0;
    int          m_phase = 0; // 0 idle, 1 addr, 2 data, 3 ignore, 4 halt
    int          m_slot  = 0;
    int          m_grp   = 0;
    bit          m_live  = 0;
    bit          m_err   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trip_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .adr_sel_i(adr_sel), .sda_drive_o(sda_drive),
        .main_div_o(main_div), .ref_div_o(ref_div),
        .thr_a_o(thr_a), .thr_b_o(thr_b), .thr_c_o(thr_c),
        .dac_a_o(dac_a), .dac_b_o(dac_b), .dac_c_o(dac_c),
        .loop_ctl_o(loop_ctl), .sw_o(sw), .mode_o(mode), .commit_o(commit)
    );

    wire [71:0] dut_vec = {main_div, ref_div, thr_a, thr_b, thr_c,
                           dac_a, dac_b, dac_c, loop_ctl, sw, mode};

    // Every clock: outputs and commit pulse against the model (R8)
    always @(negedge clk) begin
        checks++;
        if (dut_vec !== e_act || commit !== e_commit) begin
            errors++;
            $display("FAIL R8 clock compare actual %h/%b expected %h/%b",
                     dut_vec, commit, e_act, e_commit);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog actual %0d expected fewer cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_apply(input logic [7:0] b);
        if (m_slot == 0) m_grp = int'(b[7:6]);
        case (m_grp)
            0: begin
                if (m_slot == 0) e_sh[71:69] = b[2:0];
                if (m_slot == 1) e_sh[68:63] = b[5:0];
                if (m_slot == 2) e_sh[62:57] = b[5:0];
            end
            1: begin
                if (m_slot == 0) begin e_sh[56] = b[4]; e_sh[47:44] = b[3:0]; end
                if (m_slot == 1) begin e_sh[55:52] = b[7:4]; e_sh[43:40] = b[3:0]; end
                if (m_slot == 2) begin e_sh[51:48] = b[7:4]; e_sh[39:36] = b[3:0]; end
            end
            2: begin
                if (m_slot == 1) e_sh[35:28] = b;
                if (m_slot == 2) e_sh[27:20] = b;
            end
            default: begin
                if (m_slot == 0) e_sh[11:7] = b[4:0];
                if (m_slot == 1) begin e_sh[6:4] = b[7:5]; e_sh[3:0] = b[3:0]; end
                if (m_slot == 2) e_sh[19:12] = b;
            end
        endcase
        m_slot = (m_slot + 1) % 3;
    endfunction

    function automatic void model_start();
        if (m_phase == 0) begin
            e_sh = e_act; m_live = 0; m_err = 0; m_slot = 0; m_phase = 1;
        end else if (m_phase == 4) begin
            m_phase = 4;
        end else if (m_live && m_slot != 0) begin
            m_err = 1; m_phase = 4;
        end else begin
            m_phase = 1;
        end
    endfunction

    task automatic tx_start();
        model_start();
        wait_n(8); sda_m = 1'b0;
        wait_n(8); scl_m = 1'b0;
        wait_n(4);
    endtask

    task automatic tx_rstart();
        model_start();
        sda_m = 1'b1; wait_n(4);
        scl_m = 1'b1; wait_n(8);
        sda_m = 1'b0; wait_n(8);
        scl_m = 1'b0; wait_n(4);
    endtask

    task automatic tx_byte(input logic [7:0] b, input string tag);
        bit exp_ack;
        bit got_ack;
        if (m_phase == 1) begin
            exp_ack = (b == {5'b11000, adr_sel, 2'b00});
            m_phase = exp_ack ? 2 : 3;
            if (exp_ack) m_live = 1;
        end else if (m_phase == 2) begin
            exp_ack = 1;
            model_apply(b);
        end else begin
            exp_ack = 0;
        end
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(4);
            scl_m = 1'b1; wait_n(8);
            scl_m = 1'b0; wait_n(4);
        end
        sda_m = 1'b1; wait_n(4);
        scl_m = 1'b1; wait_n(4);
        got_ack = !sda_bus;
        chk({tag, " ack"}, {31'd0, got_ack}, {31'd0, exp_ack});
        wait_n(4);
        scl_m = 1'b0; wait_n(4);
        chk("R13 release after ack clock", {31'd0, sda_drive}, 32'd0);
    endtask

    task automatic tx_stop();
        sda_m = 1'b0; wait_n(4);
        scl_m = 1'b1; wait_n(8);
        @(negedge clk); sda_m = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        if (m_phase != 0 && m_live && !m_err) begin
            e_act = e_sh; e_commit = 1'b1;
        end
        m_phase = 0; m_live = 0; m_err = 0;
        @(posedge clk); #1 e_commit = 1'b0;
        wait_n(8);
    endtask

    initial begin
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; adr_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset fields", {31'd0, |dut_vec}, 32'd0);
        chk("R12 reset commit", {31'd0, commit}, 32'd0);
        chk("R12 reset sda", {31'd0, sda_drive}, 32'd0);
        rst_n = 1'b1;
        wait_n(4);

        // A and D triplets, select 0
        tx_start();
        tx_byte(8'hC0, "R1 addr sel0");
        tx_byte(8'h05, "R3 A1"); tx_byte(8'h2A, "R4 A2"); tx_byte(8'h15, "R4 A3");
        tx_byte(8'hD5, "R3 D1"); tx_byte(8'hA9, "R7 D2"); tx_byte(8'h3C, "R7 D3");
        chk("R8 no change before stop", {17'd0, main_div}, 32'd0);
        tx_stop();
        chk("R4 main divider", {17'd0, main_div}, 32'h5A95);
        chk("R7 loop ctl", {27'd0, loop_ctl}, 32'h15);
        chk("R7 switches", {29'd0, sw}, 32'h5);
        chk("R7 mode", {28'd0, mode}, 32'h9);
        chk("R7 dac c", {24'd0, dac_c}, 32'h3C);

        // Address refusals, select 1
        adr_sel = 1'b1;
        tx_start(); tx_byte(8'hC0, "R2 wrong addr"); tx_byte(8'h03, "R2 ignored byte"); tx_stop();
        tx_start(); tx_byte(8'hC5, "R2 read addr"); tx_stop();
        chk("R2 unchanged", {17'd0, main_div}, 32'h5A95);
        tx_start(); tx_byte(8'hC4, "R1 addr sel1"); tx_stop();

        // B and C triplets
        tx_start();
        tx_byte(8'hC4, "R1 addr");
        tx_byte(8'h5A, "R3 B1"); tx_byte(8'h7C, "R5 B2"); tx_byte(8'h93, "R5 B3");
        tx_byte(8'h80, "R3 C1"); tx_byte(8'h11, "R6 C2"); tx_byte(8'hEE, "R6 C3");
        chk("R8 dac a held", {24'd0, dac_a}, 32'h00);
        tx_stop();
        chk("R5 ref divider", {23'd0, ref_div}, 32'h179);
        chk("R5 thresholds", {20'd0, thr_a, thr_b, thr_c}, 32'hAC3);
        chk("R6 dac a", {24'd0, dac_a}, 32'h11);
        chk("R6 dac b", {24'd0, dac_b}, 32'hEE);

        // Partial triplet at STOP
        tx_start(); tx_byte(8'hC4, "R1 addr");
        tx_byte(8'h02, "R9 A1"); tx_byte(8'h3F, "R9 A2");
        tx_stop();
        chk("R9 partial commit", {17'd0, main_div}, 32'h2FD5);

        // Framing error: restart inside a triplet
        tx_start(); tx_byte(8'hC4, "R1 addr");
        tx_byte(8'hC0, "R10 D1");
        tx_rstart();
        tx_byte(8'hC4, "R10 addr after error");
        tx_byte(8'h80, "R10 byte after error");
        tx_stop();
        chk("R10 no commit", {27'd0, loop_ctl}, 32'h15);
        tx_start(); tx_byte(8'hC4, "R1 addr"); tx_byte(8'h07, "R10 A1"); tx_stop();
        chk("R10 shadow discarded", {27'd0, loop_ctl}, 32'h15);
        chk("R10 main after fresh", {17'd0, main_div}, 32'h7FD5);

        // Restart at a triplet boundary
        tx_start(); tx_byte(8'hC4, "R1 addr");
        tx_byte(8'h80, "R11 C1"); tx_byte(8'h42, "R11 C2"); tx_byte(8'h24, "R11 C3");
        tx_rstart();
        tx_byte(8'hC4, "R11 addr again");
        tx_byte(8'hC3, "R11 D1");
        tx_stop();
        chk("R11 dac a", {24'd0, dac_a}, 32'h42);
        chk("R11 dac b", {24'd0, dac_b}, 32'h24);
        chk("R11 loop ctl", {27'd0, loop_ctl}, 32'h03);

        wait_n(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule